// File: doc/BRIEF.md
# Pulse Period and Duty Measurement Timer

This block times an external pulse train against the system clock. A free-running up-counter restarts on every cycle-start edge of the input. A control bit picks whether the rising or the falling transition begins a cycle. The counter value at the next cycle-start edge gives the period. The counter value at the opposite transition gives the width, meaning the length of the level that follows the start edge. Every completed width and period goes out on a capture strobe and is compared against a programmable ceiling and floor. Any breach raises a sticky status flag.

A stop-on-violation enable freezes measurement while any limit flag is set. Measurement restarts once those flags are cleared. If the counter wraps while the block is still waiting for its first start edge, the input is reported as stalled. That waiting period begins when measurement is enabled and again after each restart. The status bits are cleared by writing 1 to them.

The controller has four states:
- `S_IDLE`: measurement is disabled and the counter is held at zero.
- `S_ARM`: the counter runs while the block waits for the first start edge.
- `S_MEAS`: captures are produced.
- `S_HALT`: the counter is held at zero after a limit breach.

The transitions are:
- IDLE→ARM when `meas_en` rises.
- ARM→MEAS on the first start edge.
- ARM or MEAS→HALT when `halt_en` is set and any limit flag is set.
- HALT→ARM when that condition drops.
- Any state→IDLE when `meas_en` is low.

Top module: `pulse_meas_top`

## Requirements
- R1: After reset all six status bits are 0 and neither capture strobe is asserted.
- R2: With `edge_sel`=0 the rising input edge starts a cycle. `width_out` is the number of clock cycles from a rising edge to the next falling edge. `period_out` is the number of clock cycles between consecutive rising edges. Each value is reported with a one-cycle strobe, width and period in the order they complete.
- R3: With `edge_sel`=1 the falling edge starts a cycle. Width is then the low time, and period is falling-to-falling.
- R4: After measurement is enabled, no capture is produced before the first start edge. This includes an opposite edge seen before that start edge. The first start edge only clears the counter.
- R5: A completed width above `wid_max` sets status bit 2. A completed width below `wid_min` sets status bit 3.
- R6: A completed period above `per_max` sets status bit 4. A completed period below `per_min` sets status bit 5.
- R7: Status bits are sticky. Writing 1 to a bit of `flag_clr` clears only that bit. A bit being set in the same cycle stays set.
- R8: With `halt_en`=1, once any of status bits 2 to 5 is set, no further captures occur while they remain set.
- R9: Clearing the limit flags while halted restarts measurement. The first start edge after the restart is discarded as in R4.
- R10: When the counter wraps from all ones to zero while counting, status bit 0 (overflow) is set.
- R11: A wrap before the first start edge, after enable or after a restart, also sets status bit 1 (stall). A wrap after that edge leaves bit 1 unchanged.
- R12: With `meas_en`=0 the input is ignored: no captures and no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse input |
| meas_en | input | 1 | Enable cycle measurement |
| edge_sel | input | 1 | 0: rising edge starts a cycle, 1: falling edge |
| halt_en | input | 1 | Stop measurement while a limit flag is set |
| wid_max | input | CNT_W | Width ceiling |
| wid_min | input | CNT_W | Width floor |
| per_max | input | CNT_W | Period ceiling |
| per_min | input | CNT_W | Period floor |
| flag_clr | input | 6 | Write-1-to-clear strobes for the status bits |
| flags | output | 6 | Status: 0 overflow, 1 stall, 2 width high, 3 width low, 4 period high, 5 period low |
| period_out | output | CNT_W | Last captured period |
| width_out | output | CNT_W | Last captured width |
| period_stb | output | 1 | One-cycle strobe when a period is captured |
| width_stb | output | 1 | One-cycle strobe when a width is captured |

## Verification
Pulse trains are run in both edge-select modes with several high and low times, including a long low phase against a short high phase. This separates width from period and shows whether the mode bit swaps the two levels. One run begins with the input on the wrong level, so a stray opposite edge comes before the first start edge and must be dropped. Trains that break each limit in turn show which of the four flags is tied to which comparison. A halted train shows that captures stop and then restart cleanly once the flags are cleared. A held input shows whether stall is flagged after enable and after a restart, and whether a wrap inside a started cycle sets overflow alone.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_ARM,
        S_MEAS,
        S_HALT
    } pm_state_e;

    localparam int NFLAGS     = 6;
    localparam int FLAG_OVF   = 0;
    localparam int FLAG_STALL = 1;
    localparam int FLAG_WHI   = 2;
    localparam int FLAG_WLO   = 3;
    localparam int FLAG_PHI   = 4;
    localparam int FLAG_PLO   = 5;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic edge_sel,
    output logic start_e,
    output logic end_e
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_q;
    logic          synced;
    logic          prev;
    logic          rise;
    logic          fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[LAST-1:0], din};
    end

    assign synced  = sh_q[LAST-1];
    assign prev    = sh_q[LAST];
    assign rise    = synced & ~prev;
    assign fall    = ~synced & prev;
    assign start_e = edge_sel ? fall : rise;
    assign end_e   = edge_sel ? rise : fall;
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
    import pm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_en,
    input  logic             halt_req,
    input  logic             start_e,
    input  logic             end_e,
    output logic             wrap,
    output logic             stall_set,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] wid_q,
    output logic             per_stb_q,
    output logic             wid_stb_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pm_state_e        state_q;
    pm_state_e        nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             counting;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt;
    end

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            S_IDLE: if (meas_en) nxt = S_ARM;
            S_ARM: begin
                if (!meas_en)     nxt = S_IDLE;
                else if (halt_req) nxt = S_HALT;
                else if (start_e)  nxt = S_MEAS;
            end
            S_MEAS: begin
                if (!meas_en)      nxt = S_IDLE;
                else if (halt_req) nxt = S_HALT;
            end
            S_HALT: begin
                if (!meas_en)       nxt = S_IDLE;
                else if (!halt_req) nxt = S_ARM;
            end
        endcase
    end

    assign counting  = (state_q == S_ARM) || (state_q == S_MEAS);
    assign wrap      = counting && (cnt_q == CNT_MAX) && !start_e;
    assign stall_set = wrap && (state_q == S_ARM);

    // counter and capture outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            per_q     <= '0;
            wid_q     <= '0;
            per_stb_q <= 1'b0;
            wid_stb_q <= 1'b0;
        end else begin
            per_stb_q <= 1'b0;
            wid_stb_q <= 1'b0;
            unique case (state_q)
                S_IDLE, S_HALT: cnt_q <= '0;
                S_ARM:          cnt_q <= start_e ? '0 : cnt_q + 1'b1;
                S_MEAS: begin
                    cnt_q <= start_e ? '0 : cnt_q + 1'b1;
                    if (nxt == S_MEAS) begin
                        if (start_e) begin
                            per_q     <= cnt_q + 1'b1;
                            per_stb_q <= 1'b1;
                        end
                        if (end_e) begin
                            wid_q     <= cnt_q + 1'b1;
                            wid_stb_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    a_r4_arm_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARM) |=> (!per_stb_q && !wid_stb_q));

    a_r8_halt_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> (!per_stb_q && !wid_stb_q));

    a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> (!per_stb_q && !wid_stb_q && cnt_q == '0));
endmodule

// File: rtl/pm_limits.sv
module pm_limits
    import pm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_stb,
    input  logic              wid_stb,
    input  logic [CNT_W-1:0]  per_v,
    input  logic [CNT_W-1:0]  wid_v,
    input  logic [CNT_W-1:0]  wid_max,
    input  logic [CNT_W-1:0]  wid_min,
    input  logic [CNT_W-1:0]  per_max,
    input  logic [CNT_W-1:0]  per_min,
    input  logic              ovf_set,
    input  logic              stall_set,
    input  logic [NFLAGS-1:0] clr,
    output logic [NFLAGS-1:0] flags_q
);
    logic [NFLAGS-1:0] set_v;

    always_comb begin
        set_v             = '0;
        set_v[FLAG_OVF]   = ovf_set;
        set_v[FLAG_STALL] = stall_set;
        set_v[FLAG_WHI]   = wid_stb && (wid_v > wid_max);
        set_v[FLAG_WLO]   = wid_stb && (wid_v < wid_min);
        set_v[FLAG_PHI]   = per_stb && (per_v > per_max);
        set_v[FLAG_PLO]   = per_stb && (per_v < per_min);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr) | set_v;
    end

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((flags_q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/pulse_meas_top.sv
module pulse_meas_top
    import pm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    input  logic              meas_en,
    input  logic              edge_sel,
    input  logic              halt_en,
    input  logic [CNT_W-1:0]  wid_max,
    input  logic [CNT_W-1:0]  wid_min,
    input  logic [CNT_W-1:0]  per_max,
    input  logic [CNT_W-1:0]  per_min,
    input  logic [NFLAGS-1:0] flag_clr,
    output logic [NFLAGS-1:0] flags,
    output logic [CNT_W-1:0]  period_out,
    output logic [CNT_W-1:0]  width_out,
    output logic              period_stb,
    output logic              width_stb
);
    logic start_e;
    logic end_e;
    logic wrap;
    logic stall_set;
    logic halt_req;

    assign halt_req = halt_en && (|flags[FLAG_PLO:FLAG_WHI]);

    pm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (pulse_in),
        .edge_sel (edge_sel),
        .start_e  (start_e),
        .end_e    (end_e)
    );

    pm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_en   (meas_en),
        .halt_req  (halt_req),
        .start_e   (start_e),
        .end_e     (end_e),
        .wrap      (wrap),
        .stall_set (stall_set),
        .per_q     (period_out),
        .wid_q     (width_out),
        .per_stb_q (period_stb),
        .wid_stb_q (width_stb)
    );

    pm_limits #(.CNT_W(CNT_W)) u_limits (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_stb   (period_stb),
        .wid_stb   (width_stb),
        .per_v     (period_out),
        .wid_v     (width_out),
        .wid_max   (wid_max),
        .wid_min   (wid_min),
        .per_max   (per_max),
        .per_min   (per_min),
        .ovf_set   (wrap),
        .stall_set (stall_set),
        .clr       (flag_clr),
        .flags_q   (flags)
    );
endmodule

// File: tb/test_pulse_meas_top.sv
module test_pulse_meas_top;
    localparam int W    = 12;
    localparam int WAIT = (1 << W) + 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pulse_in = 1'b0;
    logic         meas_en = 1'b0;
    logic         edge_sel = 1'b0;
    logic         halt_en = 1'b0;
    logic [W-1:0] wid_max = '1;
    logic [W-1:0] wid_min = '0;
    logic [W-1:0] per_max = '1;
    logic [W-1:0] per_min = '0;
    logic [5:0]   flag_clr = '0;
    logic [5:0]   flags;
    logic [W-1:0] period_out;
    logic [W-1:0] width_out;
    logic         period_stb;
    logic         width_stb;

    always #10 clk = ~clk;

    pulse_meas_top #(.CNT_W(W)) i_pulse_meas_top (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .meas_en(meas_en),
        .edge_sel(edge_sel), .halt_en(halt_en), .wid_max(wid_max),
        .wid_min(wid_min), .per_max(per_max), .per_min(per_min),
        .flag_clr(flag_clr), .flags(flags), .period_out(period_out),
        .width_out(width_out), .period_stb(period_stb), .width_stb(width_stb)
    );

    typedef struct {
        bit    is_per;
        int    val;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(bit is_per, int val, string req);
        exp_t e;
        e.is_per = is_per;
        e.val    = val;
        e.req    = req;
        q.push_back(e);
    endtask

    task automatic take(bit is_per, int val);
        exp_t e;
        if (q.size() == 0) begin
            checks++;
            failures++;
            $display("FAIL R4 R8 R12 unexpected capture actual=%0d expected=none", val);
        end else begin
            e = q.pop_front();
            check(e.req, (is_per ? 100000 : 0) + val, (e.is_per ? 100000 : 0) + e.val);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (width_stb)  take(1'b0, int'(width_out));
            if (period_stb) take(1'b1, int'(period_out));
        end
    end

    // driver: phase a follows the start edge, phase b follows the opposite edge
    task automatic train(int a, int b, int n, bit fall, string req, bit expect_cap);
        if (expect_cap) begin
            for (int i = 0; i < n; i++) begin
                if (i > 0) push(1'b1, a + b, req);
                push(1'b0, a, req);
            end
        end
        for (int i = 0; i < n; i++) begin
            pulse_in = ~fall;
            repeat (a) @(negedge clk);
            pulse_in = fall;
            repeat (b) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic restart(bit fall);
        meas_en  = 1'b0;
        pulse_in = fall;
        repeat (4) @(negedge clk);
        edge_sel = fall;
        meas_en  = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_flags(logic [5:0] v);
        flag_clr = v;
        @(negedge clk);
        flag_clr = '0;
        @(negedge clk);
    endtask

    task automatic wrap_up();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        wrap_up();
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 flags", int'(flags), 0);
        check("R1 strobes", int'({period_stb, width_stb}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after release", int'(flags), 0);

        // R2 rising mode, two shapes
        restart(1'b0);
        train(5, 7, 4, 1'b0, "R2", 1'b1);
        restart(1'b0);
        train(13, 3, 3, 1'b0, "R2", 1'b1);
        check("R5 no false limit flags", int'(flags), 0);

        // R3 falling mode
        restart(1'b1);
        train(4, 9, 3, 1'b1, "R3", 1'b1);

        // R4 stray opposite edge before first start edge
        meas_en  = 1'b0;
        pulse_in = 1'b1;
        repeat (4) @(negedge clk);
        edge_sel = 1'b0;
        meas_en  = 1'b1;
        repeat (3) @(negedge clk);
        pulse_in = 1'b0;
        repeat (5) @(negedge clk);
        train(6, 6, 2, 1'b0, "R4", 1'b1);
        check("R4 queue drained", q.size(), 0);

        // R5 / R6 limits
        wid_max = 12'd4;
        per_min = 12'd10;
        restart(1'b0);
        train(6, 2, 3, 1'b0, "R5", 1'b1);
        check("R5 width high only", int'(flags[3:2]), 1);
        check("R6 period low only", int'(flags[5:4]), 2);
        clear_flags(6'b000100);
        check("R7 single clear", int'(flags), 6'b100000);
        clear_flags(6'b111111);
        check("R7 all cleared", int'(flags), 0);
        wid_max = '1;
        per_min = '0;
        wid_min = 12'd3;
        per_max = 12'd20;
        restart(1'b0);
        train(2, 30, 2, 1'b0, "R6", 1'b1);
        check("R5 width low only", int'(flags[3:2]), 2);
        check("R6 period high only", int'(flags[5:4]), 1);
        clear_flags(6'b111111);
        wid_min = '0;
        per_max = '1;

        // R8 halt on violation
        halt_en = 1'b1;
        wid_max = 12'd4;
        restart(1'b0);
        push(1'b0, 6, "R8");
        train(6, 4, 3, 1'b0, "R8", 1'b0);
        check("R8 flag set", int'(flags[2]), 1);
        check("R8 no capture while halted", q.size(), 0);

        // R9 / R11 restart, stall after restart
        wid_max = '1;
        clear_flags(6'b111111);
        repeat (WAIT) @(negedge clk);
        check("R11 stall after restart", int'(flags[1]), 1);
        check("R10 overflow after restart", int'(flags[0]), 1);
        clear_flags(6'b111111);
        train(5, 5, 3, 1'b0, "R9", 1'b1);
        check("R9 clean resume", int'(flags), 0);
        halt_en = 1'b0;

        // R11 stall after enable, R10 wrap inside a started cycle
        restart(1'b0);
        repeat (WAIT) @(negedge clk);
        check("R11 stall after enable", int'(flags[1:0]), 3);
        clear_flags(6'b111111);
        pulse_in = 1'b1;
        repeat (WAIT) @(negedge clk);
        check("R10 overflow in cycle", int'(flags[0]), 1);
        check("R11 no stall in cycle", int'(flags[1]), 0);
        restart(1'b0);
        clear_flags(6'b111111);

        // R12 disabled
        meas_en = 1'b0;
        repeat (4) @(negedge clk);
        train(5, 5, 3, 1'b0, "R12", 1'b0);
        check("R12 no flags", int'(flags), 0);
        check("R12 no captures", q.size(), 0);

        check("R2 all expected captures seen", q.size(), 0);
        wrap_up();
    end
endmodule